// File: doc/BRIEF.md
# Watchdog Timer with Pre-Fault Pulse

This block watches a single activity line driven by a processor and concludes that software has stalled when the line stops changing. Every change of level, in either direction, counts as a sign of life and restarts the timing window. When a whole window passes without a change, the block first drops a short active-low warning pulse. A few cycles later it drops a sticky active-low fault output. The fault stays low until activity resumes. While the line stays idle, the warning pulse repeats once per window.

An optional two-strike latch turns two back-to-back silent windows into a persistent active-low shutdown request. The latch is set by a window expiry that finds the fault output still low. Only a dedicated clear input releases it, so a system reset that it causes cannot undo it. A system-reset strobe stops the watchdog, clears its timers and forces the warning and fault outputs high.

The window length has two parameter values, chosen by a select input. The warning width and the warning-to-fault spacing are also cycle-count parameters. The activity input must already be synchronised to the clock.

Top module: `wdog_prefault`

## Requirements
- R1: After the power-on reset `rst_n` is released, `warn_n_o`, `fault_n_o` and `shutdown_n_o` are all high.
- R2: Every level change of `kick_i`, including both edges of a one-cycle pulse, restarts the window, which is counted from the last change; no warning occurs earlier than one full window after it.
- R3: With `period_sel_i` = 0 the window is `PERIOD_DEF` cycles and with `period_sel_i` = 1 it is `PERIOD_ALT` cycles. If the clock edge that samples a change of `kick_i` is edge k, `warn_n_o` is low from edge k+P onwards.
- R4: Each warning keeps `warn_n_o` low for exactly `PULSE_W` cycles.
- R5: `fault_n_o` falls `FAULT_DLY` cycles after `warn_n_o` falls, while the warning is still low, and then stays low with no further activity.
- R6: The clock edge that samples a change of `kick_i` returns `fault_n_o` high and cancels a fault that is pending but not yet shown.
- R7: While `kick_i` stays idle, the warning repeats every window: low for `PULSE_W` cycles starting at edges k+nP, for n = 1, 2, ...
- R8: While `sys_reset_i` is high, `warn_n_o` and `fault_n_o` are high from the next clock edge onwards, and the window counter stays at zero. After release, the first warning comes a full window after the last edge that sampled the reset.
- R9: With `twofault_en_i` = 1, a window expiry that finds `fault_n_o` already low drives `shutdown_n_o` low from that edge onwards, i.e. at edge k+2P when the input stays idle. The latch is kept through `sys_reset_i`.
- R10: A change of `kick_i` between the first and the second expiry keeps `shutdown_n_o` high.
- R11: `shutdown_clr_i` high returns `shutdown_n_o` high on the next edge. With `twofault_en_i` = 0 the latch is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_reset_i | input | 1 | System reset active: halts and clears the watchdog |
| kick_i | input | 1 | Synchronised activity line from the processor |
| period_sel_i | input | 1 | Window select: 0 default, 1 alternate |
| twofault_en_i | input | 1 | Enables the two-strike shutdown latch |
| shutdown_clr_i | input | 1 | Synchronous clear of the shutdown latch |
| warn_n_o | output | 1 | Warning pulse, active low |
| fault_n_o | output | 1 | Sticky fault, active low |
| shutdown_n_o | output | 1 | Two-strike shutdown request, active low |

## Verification
All timing is counted from edge k, the clock edge that first samples a change on `kick_i`. After that edge the warning is due at k+P, the fault at k+P+FAULT_DLY, and the shutdown at k+2P. The warning and fault releases are due one edge after a change or a reset sample, and the latch clear is also due one edge after it is requested. The bench changes inputs just after a falling clock edge and reads outputs at every later falling edge. It indexes each sample by the number of rising edges since k and compares it against a formula in that index, so every cycle of a window is checked rather than a chosen few.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        PER_DEFAULT   = 1'b0,
        PER_ALTERNATE = 1'b1
    } per_sel_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdog_kick_edge.sv
module wdog_kick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic edge_o
);

    typedef struct packed {
        logic kick;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kick = kick_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a level change in either direction is activity
    assign edge_o = kick_i ^ st_q.kick;

endmodule

// File: rtl/wdog_period_timer.sv
module wdog_period_timer
    import wdog_pkg::*;
#(
    parameter int unsigned PERIOD_DEF = 16000,
    parameter int unsigned PERIOD_ALT = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic restart_i,
    input  logic sel_i,
    output logic expire_o
);

    localparam int unsigned LIM_MAX = umax(PERIOD_DEF, PERIOD_ALT);
    localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    per_sel_e         sel;
    logic [CNT_W-1:0] last;

    assign sel = per_sel_e'(sel_i);

    always_comb begin
        case (sel)
            PER_ALTERNATE: last = CNT_W'(PERIOD_ALT - 1);
            default:       last = CNT_W'(PERIOD_DEF - 1);
        endcase
    end

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (hold_i || restart_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= last) begin
            // a switch to the shorter window expires at once
            expire_o = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(LIM_MAX)); // R3

    AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q.cnt == '0) && !expire_o); // R8

endmodule

// File: rtl/wdog_alarm_seq.sv
module wdog_alarm_seq #(
    parameter int unsigned PULSE_W   = 170,
    parameter int unsigned FAULT_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic clear_i,
    input  logic expire_i,
    output logic warn_n_o,
    output logic fault_n_o
);

    localparam int unsigned W_W = $clog2(PULSE_W + 1);
    localparam int unsigned D_W = $clog2(FAULT_DLY + 1);

    typedef struct packed {
        logic [W_W-1:0] warn_cnt;
        logic [D_W-1:0] dly_cnt;
        logic           fault;
    } alarm_state_t;

    alarm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d = '0;
        end else begin
            // warning width runs to completion once started
            if (expire_i)
                st_d.warn_cnt = W_W'(PULSE_W);
            else if (st_q.warn_cnt != '0)
                st_d.warn_cnt = st_q.warn_cnt - W_W'(1);

            if (clear_i)
                st_d.dly_cnt = '0;
            else if (expire_i)
                st_d.dly_cnt = D_W'(FAULT_DLY);
            else if (st_q.dly_cnt != '0)
                st_d.dly_cnt = st_q.dly_cnt - D_W'(1);

            if (clear_i)
                st_d.fault = 1'b0;
            else if (st_q.dly_cnt == D_W'(1))
                st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign warn_n_o  = (st_q.warn_cnt == '0);
    assign fault_n_o = !st_q.fault;

    AST_WARN_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn_n_o) |-> $past(expire_i)); // R3

    AST_FAULT_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n_o) |-> !$past(clear_i) && !$past(hold_i)); // R6

endmodule

// File: rtl/wdog_fault_latch.sv
module wdog_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic clear_i,
    input  logic strike_i,
    input  logic fault_n_i,
    output logic shutdown_n_o
);

    typedef struct packed {
        logic trip;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i)
            st_d.trip = 1'b0;
        else if (enable_i && strike_i && !fault_n_i)
            st_d.trip = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shutdown_n_o = !st_q.trip;

    AST_LATCH_NEEDS_STRIKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown_n_o) |-> $past(strike_i)); // R9

endmodule

// File: rtl/wdog_prefault.sv
module wdog_prefault #(
    parameter int unsigned PERIOD_DEF = 16000,
    parameter int unsigned PERIOD_ALT = 4000,
    parameter int unsigned PULSE_W    = 170,
    parameter int unsigned FAULT_DLY  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_reset_i,
    input  logic kick_i,
    input  logic period_sel_i,
    input  logic twofault_en_i,
    input  logic shutdown_clr_i,
    output logic warn_n_o,
    output logic fault_n_o,
    output logic shutdown_n_o
);

    logic kick_edge;
    logic expire;

    wdog_kick_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_i (kick_i),
        .edge_o (kick_edge)
    );

    wdog_period_timer #(
        .PERIOD_DEF (PERIOD_DEF),
        .PERIOD_ALT (PERIOD_ALT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (sys_reset_i),
        .restart_i (kick_edge),
        .sel_i     (period_sel_i),
        .expire_o  (expire)
    );

    wdog_alarm_seq #(
        .PULSE_W   (PULSE_W),
        .FAULT_DLY (FAULT_DLY)
    ) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (sys_reset_i),
        .clear_i   (kick_edge),
        .expire_i  (expire),
        .warn_n_o  (warn_n_o),
        .fault_n_o (fault_n_o)
    );

    wdog_fault_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (twofault_en_i),
        .clear_i      (shutdown_clr_i),
        .strike_i     (expire),
        .fault_n_i    (fault_n_o),
        .shutdown_n_o (shutdown_n_o)
    );

    AST_EDGE_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        kick_edge |=> fault_n_o); // R6

    AST_RESET_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_i |=> warn_n_o && fault_n_o); // R8

    AST_FAULT_INSIDE_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n_o) |-> !warn_n_o); // R5

    AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown_n_o) |-> $past(!fault_n_o && twofault_en_i)); // R9

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_clr_i |=> shutdown_n_o); // R11

    AST_NO_WARN_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        kick_edge |=> !$fell(warn_n_o)); // R2

endmodule

// File: tb/wdog_prefault_bench.sv
module wdog_prefault_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PDEF = 20;
    localparam int PALT = 12;
    localparam int PW   = 5;
    localparam int FD   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_reset = 1'b0;
    logic kick = 1'b0;
    logic sel = 1'b0;
    logic en = 1'b0;
    logic clr = 1'b0;
    logic warn_n, fault_n, shut_n;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_prefault #(
        .PERIOD_DEF (PDEF),
        .PERIOD_ALT (PALT),
        .PULSE_W    (PW),
        .FAULT_DLY  (FD)
    ) u_wdog_prefault (
        .clk            (clk),
        .rst_n          (rst_n),
        .sys_reset_i    (sys_reset),
        .kick_i         (kick),
        .period_sel_i   (sel),
        .twofault_en_i  (en),
        .shutdown_clr_i (clr),
        .warn_n_o       (warn_n),
        .fault_n_o      (fault_n),
        .shutdown_n_o   (shut_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // window sweep: t counts rising edges after the edge that saw the last change
    task automatic sweep(input logic s, input logic e, input logic pulse);
        int p;
        string wreq;
        p = s ? PALT : PDEF;
        @(negedge clk);
        sel = s; en = e; clr = 1'b1; kick = ~kick;
        if (pulse) begin
            @(negedge clk);
            clr = 1'b0; kick = ~kick;   // one-cycle pulse, R2
        end
        for (int t = 0; t <= 3*p + PW; t++) begin
            @(negedge clk);
            clr = 1'b0;
            if (t < p)           wreq = pulse ? "R2" : "R3";
            else if (t < p + PW) wreq = "R4";
            else if (t >= 2*p)   wreq = "R7";
            else                 wreq = "R3";
            chk(wreq, "warn_n", warn_n, !(t >= p && (t % p) < PW));
            chk("R5", "fault_n", fault_n, !(t >= p + FD));
            chk(e ? "R9" : "R11", "shutdown_n", shut_n, !(e && t >= 2*p));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                fails++;
                $display("FAIL watchdog: run did not end, actual=hung expected=done");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "warn_n", warn_n, 1'b1);
        chk("R1", "fault_n", fault_n, 1'b1);
        chk("R1", "shutdown_n", shut_n, 1'b1);

        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 2; e++)
                for (int pl = 0; pl < 2; pl++)
                    sweep(1'(s), 1'(e), 1'(pl));

        // R6 / R10: activity after the first fault
        @(negedge clk);
        sel = 1'b0; en = 1'b1; clr = 1'b1; kick = ~kick;
        for (int t = 0; t <= PDEF + FD; t++) begin
            @(negedge clk);
            clr = 1'b0;
        end
        chk("R5", "fault_n before kick", fault_n, 1'b0);
        kick = ~kick;
        for (int t = 0; t <= 2*PDEF; t++) begin
            @(negedge clk);
            if (t == 0) chk("R6", "fault_n after kick", fault_n, 1'b1);
            if (t == PDEF + FD) chk("R5", "fault_n again", fault_n, 1'b0);
            if (t < 2*PDEF) chk("R10", "shutdown_n", shut_n, 1'b1);
            else            chk("R9", "shutdown_n second strike", shut_n, 1'b0);
        end

        // R8: system reset while faulted, latch held (R9)
        sys_reset = 1'b1; en = 1'b0;
        @(negedge clk);
        chk("R8", "warn_n in reset", warn_n, 1'b1);
        chk("R8", "fault_n in reset", fault_n, 1'b1);
        chk("R9", "shutdown_n kept in reset", shut_n, 1'b0);
        repeat (2) @(negedge clk);
        sys_reset = 1'b0;
        for (int t = 1; t <= PDEF; t++) begin
            @(negedge clk);
            if (t == PDEF - 1) chk("R8", "warn_n before window", warn_n, 1'b1);
            if (t == PDEF)     chk("R8", "warn_n at window", warn_n, 1'b0);
        end

        // R11: explicit clear
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R11", "shutdown_n after clear", shut_n, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule